// File: doc/BRIEF.md
# Half-Warp Memory Coalescer

This block turns one warp-wide load or store into a stream of memory transactions. A request carries one base value for each of the 32 threads, a single immediate offset added to every base, an active-thread mask and an element size. Each thread's address is its base plus the offset. The request is handled as two groups of 16 threads. The lower group (threads 0 to 15) is always handled before the upper group (threads 16 to 31).

For each group, the block checks whether every active thread touches the element slot that matches its lane number inside one aligned segment. A segment holds 16 elements. If every active thread does, the group leaves as one wide transaction carrying a byte mask and the list of threads it serves. If any active thread breaks the rule, each active thread of that group gets its own transaction, in ascending lane order. Inactive threads never break the rule. Transactions leave through a valid/ready handshake. A new request is taken only once every transaction of the previous one has been accepted.

Top module: `half_warp_coalescer`

## Requirements
- R1: Each thread address equals `base + offset` modulo 2^32. A split transaction carries exactly that address.
- R2: After reset, `req_ready_o` is 1 and `tx_valid_o` is 0. A request is accepted only when no transaction of an earlier request is still pending. `req_ready_o` stays 0 from the cycle after accepting a request that has any active thread until its last transaction is accepted.
- R3: A group is coalesced when all of its active threads meet two conditions. First, the low `log2(16*E)` bits of thread k's address equal `k*E`. Second, the remaining upper address bits are the same for all of them. Here E is the element size in bytes and k is the lane number within the group (0..15). A coalesced group emits exactly one transaction. Its address is the segment base, with the low `log2(16*E)` bits cleared. Its thread list holds exactly that group's active threads.
- R4: In a coalesced transaction, byte-mask bit `k*E+j` is 1 for each active lane k and each j < E. Every other bit of the 64-bit mask is 0, including the bits of inactive lanes.
- R5: A group that is not coalesced emits one transaction per active thread, in ascending lane order. Each such transaction carries a byte mask with only its low E bits set and a one-hot thread list, where bit n marks warp thread n.
- R6: Every transaction of the lower group (threads 0 to 15) is emitted before any transaction of the upper group.
- R7: The size code sets E: 0 gives 1 byte, 1 gives 2 bytes, 2 gives 4 bytes, and 3 is treated as 4 bytes.
- R8: A group with no active thread emits nothing. A request with an all-zero mask completes with no transaction.
- R9: While `tx_valid_o` is 1 and `tx_ready_i` is 0, the transaction outputs hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Warp request present |
| req_ready_o | output | 1 | Request can be taken this cycle |
| req_base_i | input | 1024 | Per-thread base values; thread n in bits [32n+31:32n] |
| req_off_i | input | 32 | Immediate offset added to every base |
| req_mask_i | input | 32 | Active threads; bit n is thread n |
| req_size_i | input | 2 | Element size code (R7) |
| tx_valid_o | output | 1 | Transaction present |
| tx_ready_i | input | 1 | Transaction accepted this cycle |
| tx_addr_o | output | 32 | Transaction start address |
| tx_bmask_o | output | 64 | Byte enables relative to tx_addr_o |
| tx_threads_o | output | 32 | Threads served by the transaction |

## Verification
The coalescing decision is tried with several address patterns, at every element size. Fully contiguous aligned groups check that one wide transaction is produced. A shift of one element checks alignment and must split. Two swapped lanes check lane order inside an otherwise contiguous group. Holes in the mask check that inactive lanes are ignored. A single active lane placed at its own slot, and then at the next slot, tells a one-thread wide transaction apart from a split one. Further cases cover separate segments per group, addresses that wrap at 2^32, an all-zero mask and random bases. Random back-pressure on the output checks ordering and the holding of outputs.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  localparam int MAX_BYTES = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  function automatic logic [1:0] size_shift(acc_size_e s);
    case (s)
      SZ_BYTE: return 2'd0;
      SZ_HALF: return 2'd1;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/hwc_addr_gen.sv
module hwc_addr_gen #(
  parameter int LANES = 32,
  parameter int AW    = 32
) (
  input  logic [LANES*AW-1:0] base_i,
  input  logic [AW-1:0]       off_i,
  output logic [LANES*AW-1:0] addr_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign addr_o[g*AW +: AW] = base_i[g*AW +: AW] + off_i;
  end
endmodule

// File: rtl/hwc_lowest.sv
module hwc_lowest #(
  parameter int W = 16
) (
  input  logic [W-1:0]         req_i,
  output logic [$clog2(W)-1:0] idx_o
);
  localparam int IW = $clog2(W);

  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/hwc_half_eval.sv
module hwc_half_eval
  import hwc_pkg::*;
#(
  parameter int HALF = 16,
  parameter int AW   = 32
) (
  input  logic [HALF*AW-1:0]        addr_i,
  input  logic [HALF-1:0]           mask_i,
  input  logic [1:0]                shift_i,
  output logic                      coal_o,
  output logic [AW-1:0]             seg_o,
  output logic [HALF*MAX_BYTES-1:0] bmask_o
);
  localparam int LW = $clog2(HALF);

  logic [LW-1:0]   first;
  logic [AW-1:0]   addr_f;
  logic [AW-1:0]   lowm;
  logic [HALF-1:0] ok;

  hwc_lowest #(.W(HALF)) u_first (
    .req_i (mask_i),
    .idx_o (first)
  );

  assign addr_f = addr_i[int'(first)*AW +: AW];
  // low bits that index inside one segment of HALF elements
  assign lowm   = (AW'(1) << (LW + int'(shift_i))) - AW'(1);

  for (genvar g = 0; g < HALF; g++) begin : g_chk
    logic [AW-1:0] a;
    assign a     = addr_i[g*AW +: AW];
    assign ok[g] = !mask_i[g] ||
                   (((a & ~lowm) == (addr_f & ~lowm)) &&
                    ((a & lowm) == (AW'(g) << shift_i)));
  end

  assign coal_o = (|mask_i) && (&ok);
  assign seg_o  = addr_f & ~lowm;

  always_comb begin
    bmask_o = '0;
    for (int k = 0; k < HALF; k++) begin
      for (int j = 0; j < MAX_BYTES; j++) begin
        if (mask_i[k] && (j < (1 << shift_i))) bmask_o[(k << shift_i) + j] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/half_warp_coalescer.sv
module half_warp_coalescer
  import hwc_pkg::*;
#(
  parameter int  LANES = 32,
  parameter int  AW    = 32,
  localparam int BMW   = (LANES / 2) * MAX_BYTES
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [LANES*AW-1:0] req_base_i,
  input  logic [AW-1:0]       req_off_i,
  input  logic [LANES-1:0]    req_mask_i,
  input  logic [1:0]          req_size_i,
  output logic                tx_valid_o,
  input  logic                tx_ready_i,
  output logic [AW-1:0]       tx_addr_o,
  output logic [BMW-1:0]      tx_bmask_o,
  output logic [LANES-1:0]    tx_threads_o
);
  localparam int HALF = LANES / 2;
  localparam int LW   = $clog2(HALF);

  logic [LANES*AW-1:0] addr_d, addr_q;
  logic [LANES-1:0]    mask_q, pend_q;
  logic [1:0]          shift_q;
  logic                accept, fire, upper, coal;
  logic [HALF*AW-1:0]  cur_addr;
  logic [HALF-1:0]     cur_mask, cur_pend, half_thr;
  logic [AW-1:0]       seg;
  logic [BMW-1:0]      wide_bm, one_bm;
  logic [LW-1:0]       nxt;

  hwc_addr_gen #(.LANES(LANES), .AW(AW)) u_agen (
    .base_i (req_base_i),
    .off_i  (req_off_i),
    .addr_o (addr_d)
  );

  assign req_ready_o = ~|pend_q;
  assign tx_valid_o  = |pend_q;
  assign accept      = req_valid_i && req_ready_o;
  assign fire        = tx_valid_o && tx_ready_i;

  // lower group drains first; upper is served once lower is empty
  assign upper    = ~|pend_q[HALF-1:0];
  assign cur_addr = upper ? addr_q[LANES*AW-1 -: HALF*AW] : addr_q[HALF*AW-1:0];
  assign cur_mask = upper ? mask_q[LANES-1:HALF] : mask_q[HALF-1:0];
  assign cur_pend = upper ? pend_q[LANES-1:HALF] : pend_q[HALF-1:0];

  hwc_half_eval #(.HALF(HALF), .AW(AW)) u_eval (
    .addr_i  (cur_addr),
    .mask_i  (cur_mask),
    .shift_i (shift_q),
    .coal_o  (coal),
    .seg_o   (seg),
    .bmask_o (wide_bm)
  );

  hwc_lowest #(.W(HALF)) u_next (
    .req_i (cur_pend),
    .idx_o (nxt)
  );

  always_comb begin
    one_bm = '0;
    for (int j = 0; j < MAX_BYTES; j++) begin
      if (j < (1 << shift_q)) one_bm[j] = 1'b1;
    end
  end

  assign half_thr     = coal ? cur_mask : (HALF'(1) << nxt);
  assign tx_addr_o    = coal ? seg : cur_addr[int'(nxt)*AW +: AW];
  assign tx_bmask_o   = coal ? wide_bm : one_bm;
  assign tx_threads_o = upper ? {half_thr, {HALF{1'b0}}} : {{HALF{1'b0}}, half_thr};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      mask_q  <= '0;
      pend_q  <= '0;
      shift_q <= '0;
    end else if (accept) begin
      addr_q  <= addr_d;
      mask_q  <= req_mask_i;
      pend_q  <= req_mask_i;
      shift_q <= size_shift(acc_size_e'(req_size_i));
    end else if (fire) begin
      pend_q  <= pend_q & ~tx_threads_o;
    end
  end

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_addr_o) &&
                                  $stable(tx_bmask_o) && $stable(tx_threads_o));

  p_pending_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> ((tx_threads_o & ~pend_q) == '0) && (tx_threads_o != '0));

  p_order_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && (|tx_threads_o[LANES-1:HALF]) |-> ~|pend_q[HALF-1:0]);

  p_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !coal |-> $countones(tx_threads_o) == 1);

  p_bytes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && coal |-> $countones(tx_bmask_o) == ($countones(tx_threads_o) << shift_q));

  p_drain_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> $countones(pend_q) < $countones($past(pend_q)));
endmodule

// File: tb/tb_half_warp_coalescer.sv
`timescale 1ns/1ps
module tb_half_warp_coalescer;
  localparam int LANES = 32;
  localparam int AW    = 32;
  localparam int HALF  = 16;
  localparam int BMW   = 64;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                req_valid = 1'b0;
  logic                req_ready;
  logic [LANES*AW-1:0] req_base = '0;
  logic [AW-1:0]       req_off = '0;
  logic [LANES-1:0]    req_mask = '0;
  logic [1:0]          req_size = '0;
  logic                tx_valid;
  logic                tx_ready = 1'b0;
  logic [AW-1:0]       tx_addr;
  logic [BMW-1:0]      tx_bmask;
  logic [LANES-1:0]    tx_threads;

  int checks = 0;
  int errors = 0;

  logic [AW-1:0]    bases [LANES];
  logic [AW-1:0]    e_addr [64];
  logic [BMW-1:0]   e_bm [64];
  logic [LANES-1:0] e_thr [64];
  bit               e_coal [64];
  int               e_n;

  always #2 clk = ~clk;

  half_warp_coalescer #(.LANES(LANES), .AW(AW)) dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_valid_i  (req_valid),
    .req_ready_o  (req_ready),
    .req_base_i   (req_base),
    .req_off_i    (req_off),
    .req_mask_i   (req_mask),
    .req_size_i   (req_size),
    .tx_valid_o   (tx_valid),
    .tx_ready_i   (tx_ready),
    .tx_addr_o    (tx_addr),
    .tx_bmask_o   (tx_bmask),
    .tx_threads_o (tx_threads)
  );

  task automatic chk(bit ok, string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic int szl_of(int sz);
    return (sz >= 2) ? 2 : sz; // R7: code 3 acts as 4 bytes
  endfunction

  task automatic build_exp(logic [AW-1:0] off, logic [LANES-1:0] m, int sz);
    int esz;
    esz = 1 << szl_of(sz);
    e_n = 0;
    for (int h = 0; h < 2; h++) begin
      int f;
      bit c;
      logic [AW-1:0] seg;
      logic [AW-1:0] a [HALF];
      f = -1;
      for (int k = 0; k < HALF; k++) begin
        a[k] = bases[h*HALF+k] + off;
        if (m[h*HALF+k] && f < 0) f = k;
      end
      if (f >= 0) begin
        seg = a[f] - AW'(f * esz);
        c = (seg % AW'(HALF * esz)) == 0;
        for (int k = 0; k < HALF; k++)
          if (m[h*HALF+k] && a[k] != seg + AW'(k * esz)) c = 0;
        if (c) begin
          e_addr[e_n] = seg;
          e_bm[e_n]   = '0;
          e_thr[e_n]  = '0;
          for (int k = 0; k < HALF; k++)
            if (m[h*HALF+k]) begin
              e_thr[e_n][h*HALF+k] = 1'b1;
              for (int j = 0; j < esz; j++) e_bm[e_n][k*esz+j] = 1'b1;
            end
          e_coal[e_n] = 1;
          e_n++;
        end else begin
          for (int k = 0; k < HALF; k++)
            if (m[h*HALF+k]) begin
              e_addr[e_n] = a[k];
              e_bm[e_n]   = (BMW'(1) << esz) - BMW'(1);
              e_thr[e_n]  = LANES'(1) << (h*HALF+k);
              e_coal[e_n] = 0;
              e_n++;
            end
        end
      end
    end
  endtask

  task automatic run_req(string name, int sz, logic [AW-1:0] off, logic [LANES-1:0] m);
    int idx, guard;
    bit held, r;
    logic [AW-1:0] h_addr;
    logic [BMW-1:0] h_bm;
    logic [LANES-1:0] h_thr;
    build_exp(off, m, sz);
    for (int k = 0; k < LANES; k++) req_base[k*AW +: AW] = bases[k];
    req_off   = off;
    req_mask  = m;
    req_size  = 2'(sz);
    req_valid = 1'b1;
    chk(req_ready === 1'b1, $sformatf("R2 %s ready before accept act=%b exp=1", name, req_ready));
    @(negedge clk);
    // junk held on the request port while busy must not be taken (R2)
    req_base = ~req_base;
    req_mask = ~req_mask;
    if (e_n > 0)
      chk(req_ready === 1'b0, $sformatf("R2 %s busy ready act=%b exp=0", name, req_ready));
    else
      chk(tx_valid === 1'b0 && req_ready === 1'b1,
          $sformatf("R8 %s empty act=%b%b exp=01", name, tx_valid, req_ready));
    idx = 0; held = 0; guard = 0;
    while (!req_ready && guard < 4000) begin
      if (held)
        chk(tx_valid && tx_addr == h_addr && tx_bmask == h_bm && tx_threads == h_thr,
            $sformatf("R9 %s hold act=%h/%h exp=%h/%h", name, tx_addr, tx_threads, h_addr, h_thr));
      r = ($urandom % 4) != 0;
      if (tx_valid && r) begin
        if (idx < e_n)
          chk(tx_addr == e_addr[idx] && tx_bmask == e_bm[idx] && tx_threads == e_thr[idx],
              $sformatf("%s %s tx%0d act=%h/%h/%h exp=%h/%h/%h",
                        e_coal[idx] ? "R3 R4 R7" : "R1 R5 R6", name, idx,
                        tx_addr, tx_bmask, tx_threads, e_addr[idx], e_bm[idx], e_thr[idx]));
        else
          chk(0, $sformatf("R5 %s extra tx act=%h exp=none", name, tx_threads));
        idx++;
      end
      held = tx_valid && !r;
      h_addr = tx_addr; h_bm = tx_bmask; h_thr = tx_threads;
      tx_ready = r;
      guard++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    tx_ready  = 1'b0;
    chk(idx == e_n && guard < 4000,
        $sformatf("R3 R5 R8 %s tx count act=%0d exp=%0d", name, idx, e_n));
    @(negedge clk);
  endtask

  task automatic lin(logic [AW-1:0] b, int esz);
    for (int k = 0; k < LANES; k++) bases[k] = b + AW'(k * esz);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    chk(tx_valid === 1'b0 && req_ready === 1'b1,
        $sformatf("R2 reset state act=%b%b exp=01", tx_valid, req_ready));
    rst_n = 1'b1;
    @(negedge clk);
    for (int sz = 0; sz < 4; sz++) begin
      int esz;
      logic [AW-1:0] b;
      esz = 1 << szl_of(sz);
      b = 32'h0001_0000 + AW'(sz) * 32'h100;
      lin(b - 32'h40, esz);
      run_req("full", sz, 32'h40, '1);
      lin(b + AW'(esz), esz);
      run_req("shift", sz, 0, '1);
      lin(b, esz);
      bases[2] = b + AW'(3 * esz);
      bases[3] = b + AW'(2 * esz);
      run_req("swap", sz, 0, '1);
      lin(b, esz);
      run_req("holes", sz, 0, 32'h5A5A_F00F);
      run_req("ends", sz, 0, 32'h8000_0001);
      for (int k = HALF; k < LANES; k++) bases[k] = 32'h0F00_0000 + AW'((k - HALF) * esz);
      run_req("twoseg", sz, 0, '1);
      run_req("zero", sz, 0, '0);
      lin(32'hFFFF_FFC0, esz);
      run_req("wrap", sz, 32'h80, '1);
      run_req("wrapsplit", sz, 32'h81, 32'h0003_0003);
      for (int l = 0; l < HALF; l++) begin
        lin(b, esz);
        run_req("oneown", sz, 0, (LANES'(1) << l) | (LANES'(1) << (l + HALF)));
        bases[l] = b + AW'(((l + 1) % HALF) * esz);
        run_req("onewrong", sz, 0, LANES'(1) << l);
      end
      for (int n = 0; n < 6; n++) begin
        lin({$urandom} & 32'hFFFF_FF00, esz);
        if (n[0]) bases[$urandom % LANES] = $urandom;
        run_req("random", sz, AW'($urandom % 3) * 32'h100, $urandom);
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule